// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes configuration words from a slow three-wire serial bus and writes them into two parallel working registers. The bus has a shift clock, a strobe and a data line. The three lines are sampled by the system clock, and all edge detection is done in that clock domain. While the strobe is low, each rising edge of the shift clock moves one data bit into a 21-bit shift register.

When the strobe rises, the block inspects the word it has collected. The top four bits are a chip address. If they match the device address set by a parameter, the next bit picks one of two register banks, and that bank takes the remaining 16 payload bits. The bank that was written gives a one-cycle update pulse.

The two banks are also decoded into named fields: a reference divider ratio, a charge-pump setting, a mode selection, spare bits, a main divider count and test bits. These outputs drive the surrounding synthesizer and mode logic.

Top module: `cfg_serial_loader`

## Requirements
- R1: A synchronous reset sets bank 0 to DEF0 (default 16'h0001) and bank 1 to DEF1 (default 16'h0058), and keeps both update pulses low.
- R2: A word is 21 bits, shifted most significant bit first. Bits 20:17 are the chip address, bit 16 is the bank select (0 = bank 0, 1 = bank 1) and bits 15:0 are the payload.
- R3: While the strobe is low, each rising edge of the shift clock appends the data bit to the shift register.
- R4: While the strobe is high, shift-clock edges leave the shift register unchanged. A later strobe rise with no clocks in between re-latches the same word.
- R5: On a strobe rise whose address field equals DEV_ADDR (default 4'hA), the payload is written into the bank chosen by the select bit, within four system clocks.
- R6: On a strobe rise whose address field differs from DEV_ADDR, neither bank changes and no update pulse is issued.
- R7: If more than 21 clock edges arrive in one strobe-low window, only the last 21 bits form the word.
- R8: Each write raises the written bank's update pulse for exactly one cycle. The two pulses are never high together, and a bank's contents change only in a cycle when its pulse is high.
- R9: Bank 0 bits 1:0 select the reference divider ratio: 00 gives 8, 01 gives 11, 10 gives 22, 11 gives 44.
- R10: The decoded fields are: charge pump = bank 0 bits 4:2, mode = bank 0 bits 7:5, spare = bank 0 bits 15:8, main divider = bank 1 bits 11:0, test = bank 1 bits 15:12.
- R11: If the synchronized strobe rise and a shift-clock rise fall in the same system cycle, the clock edge is ignored and the word collected before it is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_stb | input | 1 | Serial strobe; low opens the shift window |
| ser_dat | input | 1 | Serial data |
| bank0_q | output | 16 | Bank 0 contents |
| bank1_q | output | 16 | Bank 1 contents |
| bank0_upd | output | 1 | One-cycle pulse when bank 0 is written |
| bank1_upd | output | 1 | One-cycle pulse when bank 1 is written |
| ref_ratio | output | 6 | Decoded reference divider ratio |
| cp_sel | output | 3 | Charge-pump setting |
| mode_sel | output | 3 | Mode selection |
| aux_bits | output | 8 | Spare bank 0 bits |
| main_div | output | 12 | Main divider count |
| test_bits | output | 4 | Test bits |

## Verification
Two things can happen in the same system cycle: a shift-clock rise and a strobe rise. The bench provokes this by changing both lines in the same time step. After the synchronizers, both edges are then detected on the same clock edge. The bench first collects a complete word for bank 1, then raises the clock and the strobe together. It passes only if that exact word reaches bank 1 with a single pulse. If the extra edge had been shifted in, the address field would change and the write would be lost.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam int WORD_W    = 21;
    localparam int ADDR_W    = 4;
    localparam int SUB_W     = 1;
    localparam int PAY_W     = WORD_W - ADDR_W - SUB_W;
    localparam int NUM_BANKS = 2;
    localparam int RATIO_W   = 6;
    localparam int CP_W      = 3;
    localparam int MODE_W    = 3;
    localparam int AUX_W     = PAY_W - CP_W - MODE_W - 2;
    localparam int TEST_W    = 4;
    localparam int MDIV_W    = PAY_W - TEST_W;

    typedef logic [PAY_W-1:0] payload_t;

    typedef struct packed {
        logic [ADDR_W-1:0] chip;
        logic [SUB_W-1:0]  sub;
        payload_t          payload;
    } ser_word_t;

    typedef enum logic [1:0] {
        REF_DIV8  = 2'b00,
        REF_DIV11 = 2'b01,
        REF_DIV22 = 2'b10,
        REF_DIV44 = 2'b11
    } ref_sel_e;

    typedef struct packed {
        logic [AUX_W-1:0]  aux;
        logic [MODE_W-1:0] mode;
        logic [CP_W-1:0]   cp;
        ref_sel_e          ref_sel;
    } bank0_t;

    typedef struct packed {
        logic [TEST_W-1:0] test;
        logic [MDIV_W-1:0] main_div;
    } bank1_t;

    function automatic logic [RATIO_W-1:0] ratio_of(input ref_sel_e sel);
        logic [RATIO_W-1:0] r;
        case (sel)
            REF_DIV8:  r = RATIO_W'(8);
            REF_DIV11: r = RATIO_W'(11);
            REF_DIV22: r = RATIO_W'(22);
            default:   r = RATIO_W'(44);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[g] <= RST_VAL;
                else     st[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[g] <= RST_VAL;
                else     st[g] <= st[g-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/cfg_shift_front.sv
module cfg_shift_front
    import cfg_loader_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_s,
    input  logic      stb_s,
    input  logic      dat_s,
    output ser_word_t word_o,
    output logic      latch_o
);
    logic              sclk_q;
    logic              stb_q;
    logic [WORD_W-1:0] shreg;
    logic              sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            stb_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            stb_q  <= stb_s;
        end
    end

    // Shift only while strobe is low in the very cycle the clock edge is seen
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (sclk_rise && !stb_s) begin
            shreg <= {shreg[WORD_W-2:0], dat_s};
        end
    end

    assign latch_o = stb_s & ~stb_q;
    assign word_o  = ser_word_t'(shreg);
endmodule

// File: rtl/cfg_bank_regs.sv
module cfg_bank_regs
    import cfg_loader_pkg::*;
#(
    parameter logic [ADDR_W-1:0]                   DEV_ADDR = 4'hA,
    parameter logic [NUM_BANKS-1:0][PAY_W-1:0]     DEFAULTS = '0
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               latch_i,
    input  ser_word_t                          word_i,
    output logic [NUM_BANKS-1:0][PAY_W-1:0]    bank_o,
    output logic [NUM_BANKS-1:0]               upd_o
);
    logic addr_hit;

    assign addr_hit = latch_i && (word_i.chip == DEV_ADDR);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = addr_hit && (word_i.sub == SUB_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                bank_o[b] <= DEFAULTS[b];
                upd_o[b]  <= 1'b0;
            end else begin
                upd_o[b] <= sel;
                if (sel) bank_o[b] <= word_i.payload;
            end
        end
    end
endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
    import cfg_loader_pkg::*;
(
    input  payload_t            b0,
    input  payload_t            b1,
    output logic [RATIO_W-1:0]  ref_ratio,
    output logic [CP_W-1:0]     cp_sel,
    output logic [MODE_W-1:0]   mode_sel,
    output logic [AUX_W-1:0]    aux_bits,
    output logic [MDIV_W-1:0]   main_div,
    output logic [TEST_W-1:0]   test_bits
);
    bank0_t f0;
    bank1_t f1;

    always_comb begin
        f0        = bank0_t'(b0);
        f1        = bank1_t'(b1);
        ref_ratio = ratio_of(f0.ref_sel);
        cp_sel    = f0.cp;
        mode_sel  = f0.mode;
        aux_bits  = f0.aux;
        main_div  = f1.main_div;
        test_bits = f1.test;
    end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 4'hA,
    parameter logic [PAY_W-1:0]  DEF0        = 16'h0001,
    parameter logic [PAY_W-1:0]  DEF1        = 16'h0058,
    parameter int                SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_clk,
    input  logic               ser_stb,
    input  logic               ser_dat,
    output logic [PAY_W-1:0]   bank0_q,
    output logic [PAY_W-1:0]   bank1_q,
    output logic               bank0_upd,
    output logic               bank1_upd,
    output logic [RATIO_W-1:0] ref_ratio,
    output logic [CP_W-1:0]    cp_sel,
    output logic [MODE_W-1:0]  mode_sel,
    output logic [AUX_W-1:0]   aux_bits,
    output logic [MDIV_W-1:0]  main_div,
    output logic [TEST_W-1:0]  test_bits
);
    localparam logic [NUM_BANKS-1:0][PAY_W-1:0] BANK_DEFS = {DEF1, DEF0};

    logic [2:0]                      raw_in;
    logic [2:0]                      syn_in;
    ser_word_t                       word;
    logic                            latch;
    logic [NUM_BANKS-1:0][PAY_W-1:0] banks;
    logic [NUM_BANKS-1:0]            upd;

    assign raw_in = {ser_stb, ser_clk, ser_dat};

    cfg_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    cfg_shift_front u_front (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (syn_in[1]),
        .stb_s   (syn_in[2]),
        .dat_s   (syn_in[0]),
        .word_o  (word),
        .latch_o (latch)
    );

    cfg_bank_regs #(
        .DEV_ADDR (DEV_ADDR),
        .DEFAULTS (BANK_DEFS)
    ) u_banks (
        .clk     (clk),
        .rst     (rst),
        .latch_i (latch),
        .word_i  (word),
        .bank_o  (banks),
        .upd_o   (upd)
    );

    assign bank0_q   = banks[0];
    assign bank1_q   = banks[1];
    assign bank0_upd = upd[0];
    assign bank1_upd = upd[1];

    cfg_field_decode u_dec (
        .b0        (banks[0]),
        .b1        (banks[1]),
        .ref_ratio (ref_ratio),
        .cp_sel    (cp_sel),
        .mode_sel  (mode_sel),
        .aux_bits  (aux_bits),
        .main_div  (main_div),
        .test_bits (test_bits)
    );
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] bank0_q,
    input logic [15:0] bank1_q,
    input logic        bank0_upd,
    input logic        bank1_upd,
    input logic [5:0]  ref_ratio
);
    a_r1_reset_defaults: assert property (@(posedge clk)
        rst |=> (bank0_q == 16'h0001 && bank1_q == 16'h0058 && !bank0_upd && !bank1_upd));

    a_r8_pulse0_single: assert property (@(posedge clk) disable iff (rst)
        bank0_upd |=> !bank0_upd);

    a_r8_pulse1_single: assert property (@(posedge clk) disable iff (rst)
        bank1_upd |=> !bank1_upd);

    a_r8_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(bank0_upd && bank1_upd));

    a_r8_bank0_change_flagged: assert property (@(posedge clk) disable iff (rst)
        (bank0_q != $past(bank0_q)) |-> bank0_upd);

    a_r8_bank1_change_flagged: assert property (@(posedge clk) disable iff (rst)
        (bank1_q != $past(bank1_q)) |-> bank1_upd);

    a_r9_ratio_legal: assert property (@(posedge clk) disable iff (rst)
        (ref_ratio == 6'd8 || ref_ratio == 6'd11 || ref_ratio == 6'd22 || ref_ratio == 6'd44));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bank0_q   (bank0_q),
    .bank1_q   (bank1_q),
    .bank0_upd (bank0_upd),
    .bank1_upd (bank1_upd),
    .ref_ratio (ref_ratio)
);

// File: tb/sim_cfg_serial_loader.sv
`timescale 1ns/1ps
module sim_cfg_serial_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_stb = 1'b1;
    logic        ser_dat = 1'b0;
    logic [15:0] bank0_q, bank1_q;
    logic        bank0_upd, bank1_upd;
    logic [5:0]  ref_ratio;
    logic [2:0]  cp_sel, mode_sel;
    logic [7:0]  aux_bits;
    logic [11:0] main_div;
    logic [3:0]  test_bits;

    int total = 0;
    int bad   = 0;
    int cnt0  = 0;
    int cnt1  = 0;
    int cyc   = 0;
    logic [15:0] m0, m1;

    localparam logic [3:0] DEV = 4'hA;
    localparam int NV = 7;
    localparam logic [20:0] VEC [NV] = '{
        {4'hA, 1'b0, 16'h00E6},
        {4'hA, 1'b1, 16'h5123},
        {4'h5, 1'b0, 16'hFFFF},
        {4'hA, 1'b0, 16'h00FF},
        {4'hA, 1'b0, 16'hAB00},
        {4'hB, 1'b1, 16'h0000},
        {4'hA, 1'b1, 16'hF00F}
    };

    always #4 clk = ~clk;

    cfg_serial_loader u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_stb(ser_stb), .ser_dat(ser_dat),
        .bank0_q(bank0_q), .bank1_q(bank1_q), .bank0_upd(bank0_upd), .bank1_upd(bank1_upd),
        .ref_ratio(ref_ratio), .cp_sel(cp_sel), .mode_sel(mode_sel), .aux_bits(aux_bits),
        .main_div(main_div), .test_bits(test_bits)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && bank0_upd) cnt0 <= cnt0 + 1;
        if (!rst && bank1_upd) cnt1 <= cnt1 + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        ser_stb = 1'b0;
        wt(3);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            ser_clk = 1'b0;
            wt(3);
            ser_clk = 1'b1;
            wt(3);
        end
        ser_clk = 1'b0;
        wt(3);
        ser_stb = 1'b1;
        wt(6);
    endtask

    function automatic int ratio_exp(input logic [1:0] s);
        case (s)
            2'b00: return 8;
            2'b01: return 11;
            2'b10: return 22;
            default: return 44;
        endcase
    endfunction

    task automatic check_fields();
        chk("R9 ref ratio", ref_ratio, ratio_exp(m0[1:0]));
        chk("R10 cp", cp_sel, m0[4:2]);
        chk("R10 mode", mode_sel, m0[7:5]);
        chk("R10 aux", aux_bits, m0[15:8]);
        chk("R10 main div", main_div, m1[11:0]);
        chk("R10 test", test_bits, m1[15:12]);
    endtask

    initial begin
        int c0, c1;
        wt(4);
        // R1 reset defaults
        chk("R1 bank0 default", bank0_q, 16'h0001);
        chk("R1 bank1 default", bank1_q, 16'h0058);
        chk("R1 no pulse", {bank0_upd, bank1_upd}, 0);
        rst = 1'b0;
        wt(4);
        m0 = 16'h0001;
        m1 = 16'h0058;
        check_fields();

        // R2 R3 R5 R6 R8 table walk
        for (int k = 0; k < NV; k++) begin
            c0 = cnt0;
            c1 = cnt1;
            send({11'd0, VEC[k]}, 21);
            if (VEC[k][20:17] == DEV) begin
                if (VEC[k][16]) m1 = VEC[k][15:0];
                else            m0 = VEC[k][15:0];
            end
            chk("R5 R6 bank0", bank0_q, m0);
            chk("R5 R6 bank1", bank1_q, m1);
            chk("R8 pulse0 count", cnt0 - c0,
                (VEC[k][20:17] == DEV && !VEC[k][16]) ? 1 : 0);
            chk("R8 pulse1 count", cnt1 - c1,
                (VEC[k][20:17] == DEV && VEC[k][16]) ? 1 : 0);
            check_fields();
        end

        // R7: 25 bits, last 21 form the word
        c0 = cnt0;
        send({7'd0, 4'h3, 4'hA, 1'b0, 16'h1234}, 25);
        m0 = 16'h1234;
        chk("R7 last 21 bits", bank0_q, m0);
        chk("R7 pulse", cnt0 - c0, 1);

        // R4: clocks while strobe high ignored
        c0 = cnt0;
        for (int i = 0; i < 5; i++) begin
            ser_dat = 1'b1;
            ser_clk = 1'b1;
            wt(3);
            ser_clk = 1'b0;
            wt(3);
        end
        ser_stb = 1'b0;
        wt(4);
        ser_stb = 1'b1;
        wt(6);
        chk("R4 relatch bank0", bank0_q, m0);
        chk("R4 relatch pulse", cnt0 - c0, 1);

        // R11: strobe rise coincident with a clock rise
        c1 = cnt1;
        ser_stb = 1'b0;
        wt(3);
        for (int i = 20; i >= 0; i--) begin
            ser_dat = ({4'hA, 1'b1, 16'h3C5A} >> i) & 1;
            ser_clk = 1'b0;
            wt(3);
            ser_clk = 1'b1;
            wt(3);
        end
        ser_clk = 1'b0;
        ser_dat = 1'b1;
        wt(3);
        ser_clk = 1'b1;
        ser_stb = 1'b1;
        wt(6);
        ser_clk = 1'b0;
        wt(3);
        m1 = 16'h3C5A;
        chk("R11 coincident edge ignored", bank1_q, m1);
        chk("R11 pulse", cnt1 - c1, 1);
        check_fields();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule